// File: doc/BRIEF.md
# Quadrature Position Decoder with Selectable Resolution

This block turns the two phase-shifted square waves of an incremental shaft encoder into a signed position. Each channel is first brought into the clock domain and then cleaned by a level filter. A decoder compares the cleaned pair with its previous value. Every legal single-channel step is classed as forward or backward motion. The step then counts or not, depending on the resolution the two mode pins pick.

Each counted step does three things. It sets a direction level, it raises a count strobe for one clock on the following cycle, and it moves a wide up/down position register by one. The register wraps at both ends. A system integrator sets the mode pins before motion starts, then reads the position and, if needed, taps the strobe and direction pair to drive an external counter.

Top module: `enc_pos_counter`

## Requirements
- R1: With {modeSel1,modeSel2} = 2'b10 (fine mode), every single-channel change of the filtered pair {chanA,chanB} counts once.
- R2: With {modeSel1,modeSel2} = 2'b01 (half mode), only changes of chanA count; chanB changes leave the count unchanged.
- R3: With {modeSel1,modeSel2} = 2'b11 (coarse mode), only the step {A,B} 00->10 counts (+1) and the step 10->00 counts (-1); all other steps are ignored.
- R4: With {modeSel1,modeSel2} = 2'b00 no step counts, and countPulse stays low.
- R5: The forward sequence of {A,B} is 00, 10, 11, 01, 00 (A leads B) and increments the count; the reverse order decrements it.
- R6: upDn is 1 for forward and 0 for backward, holds between counted steps, and takes its new value at least one clock before the rising edge of the matching countPulse.
- R7: Each counted step gives exactly one countPulse that is high for one clock, and count changes by exactly 1 only on the edge that raises that pulse.
- R8: A sample in which both filtered channels change at once is ignored: no pulse, no count change, upDn held.
- R9: After a two-flop synchronizer, a channel level is accepted only after 3 consecutive equal samples, so a pulse shorter than 3 clocks has no effect.
- R10: count wraps modulo 2^CNT_W: one backward step from 0 gives all ones, and one forward step from all ones gives 0.
- R11: rstN low asynchronously clears count to 0, countPulse to 0, the filters and the decoder history to 0, and sets upDn to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chanA | input | 1 | Encoder channel A, asynchronous |
| chanB | input | 1 | Encoder channel B, asynchronous |
| modeSel1 | input | 1 | Resolution select, high bit of the mode code |
| modeSel2 | input | 1 | Resolution select, low bit of the mode code |
| countPulse | output | 1 | One-clock strobe per counted step |
| upDn | output | 1 | Direction level, 1 = forward |
| count | output | CNT_W | Position register |

## Verification
The bench builds the block with its defaults: a 32-bit register, a two-stage synchronizer and a three-sample filter. With these values a single backward step from zero reaches the top of the 32-bit range, so the wrap at both ends can be checked in a few cycles. A two-clock glitch falls one sample short of the filter length, which sets the shortest rejected and the shortest accepted pulse widths side by side. The table walks all four mode codes through both directions, and directed tests cover the double-channel jump and a reset applied while the clock runs.

// File: rtl/enc_pkg.sv
package enc_pkg;

  // {modeSel1, modeSel2}
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_HALF = 2'b01,
    MODE_FINE = 2'b10,
    MODE_COARSE = 2'b11
  } enc_mode_e;

  typedef struct packed {
    logic step;
    logic up;
  } enc_strobe_t;

endpackage

// File: rtl/enc_input_cond.sv
module enc_input_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [FILT_LEN-1:0]    histQ;
  logic                   syncOut;

  assign syncOut = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histQ    <= '0;
      cleanOut <= 1'b0;
    end else begin
      histQ <= {histQ[FILT_LEN-2:0], syncOut};
      if (&histQ) begin
        cleanOut <= 1'b1;
      end else if (~|histQ) begin
        cleanOut <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/enc_decode_ctrl.sv
module enc_decode_ctrl
  import enc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        phA,
  input  logic        phB,
  input  enc_mode_e   mode,
  output enc_strobe_t strobe
);

  logic prevA;
  logic prevB;
  logic chgA;
  logic chgB;
  logic oneEdge;
  logic fwd;
  logic qualify;

  assign chgA    = phA ^ prevA;
  assign chgB    = phB ^ prevB;
  assign oneEdge = chgA ^ chgB;
  // A edge: forward when the new levels differ; B edge: forward when equal
  assign fwd     = chgA ? (phA ^ phB) : ~(phA ^ phB);

  always_comb begin
    unique case (mode)
      MODE_FINE:   qualify = oneEdge;
      MODE_HALF:   qualify = oneEdge & chgA;
      MODE_COARSE: qualify = oneEdge & chgA & ~phB;
      default:     qualify = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevA  <= 1'b0;
      prevB  <= 1'b0;
      strobe <= '0;
    end else begin
      prevA       <= phA;
      prevB       <= phB;
      strobe.step <= qualify;
      strobe.up   <= fwd;
    end
  end

endmodule

// File: rtl/enc_pos_datapath.sv
module enc_pos_datapath
  import enc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  enc_strobe_t      strobe,
  output logic             countPulse,
  output logic             upDn,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic stepDly;
  logic dirDly;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepDly    <= 1'b0;
      dirDly     <= 1'b1;
      upDn       <= 1'b1;
      countPulse <= 1'b0;
      count      <= '0;
    end else begin
      stepDly    <= strobe.step;
      dirDly     <= strobe.up;
      countPulse <= stepDly;
      if (strobe.step) begin
        upDn <= strobe.up;
      end
      if (stepDly) begin
        count <= dirDly ? count + ONE : count - ONE;
      end
    end
  end

endmodule

// File: rtl/enc_pos_counter.sv
module enc_pos_counter
  import enc_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanA,
  input  logic             chanB,
  input  logic             modeSel1,
  input  logic             modeSel2,
  output logic             countPulse,
  output logic             upDn,
  output logic [CNT_W-1:0] count
);

  localparam int NUM_CH = 2;

  logic [NUM_CH-1:0] rawCh;
  logic [NUM_CH-1:0] cleanCh;
  enc_strobe_t       strobe;
  enc_mode_e         mode;

  assign rawCh = {chanB, chanA};
  assign mode  = enc_mode_e'({modeSel1, modeSel2});

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cond
    enc_input_cond #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_cond (
      .clk     (clk),
      .rstN    (rstN),
      .rawIn   (rawCh[ch]),
      .cleanOut(cleanCh[ch])
    );
  end

  enc_decode_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .phA   (cleanCh[0]),
    .phB   (cleanCh[1]),
    .mode  (mode),
    .strobe(strobe)
  );

  enc_pos_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .countPulse(countPulse),
    .upDn      (upDn),
    .count     (count)
  );

endmodule

// File: rtl/enc_pos_counter_checker.sv
module enc_pos_counter_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             modeSel1,
  input logic             modeSel2,
  input logic             countPulse,
  input logic             upDn,
  input logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // R7: position only moves together with a strobe
  assert_hold_no_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    !countPulse |-> count == $past(count));

  // R7, R10: a strobe moves the position by exactly one, wrapping
  assert_unit_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    countPulse |-> (count == $past(count) + ONE) || (count == $past(count) - ONE));

  // R6: direction settled before the strobe rises
  assert_dir_lead_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(countPulse) |-> $stable(upDn));

  // R4: the off code never yields a strobe
  assert_off_silent_R4: assert property (@(posedge clk) disable iff (!rstN)
    countPulse |-> $past({modeSel1, modeSel2}, 3) != 2'b00);

endmodule

bind enc_pos_counter enc_pos_counter_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .modeSel1  (modeSel1),
  .modeSel2  (modeSel2),
  .countPulse(countPulse),
  .upDn      (upDn),
  .count     (count)
);

// File: tb/enc_pos_counter_bench.sv
module enc_pos_counter_bench;

  localparam int CNT_W = 32;
  localparam int NVEC  = 22;
  localparam int SETTLE = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             chanA = 1'b0;
  logic             chanB = 1'b0;
  logic             modeSel1 = 1'b1;
  logic             modeSel2 = 1'b0;
  logic             countPulse;
  logic             upDn;
  logic [CNT_W-1:0] count;

  int unsigned checks = 0;
  int unsigned errors = 0;
  int unsigned pulses = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  enc_pos_counter u_enc_pos_counter (
    .clk       (clk),
    .rstN      (rstN),
    .chanA     (chanA),
    .chanB     (chanB),
    .modeSel1  (modeSel1),
    .modeSel2  (modeSel2),
    .countPulse(countPulse),
    .upDn      (upDn),
    .count     (count)
  );

  always @(negedge clk) begin
    if (rstN && countPulse) pulses++;
  end

  // {modeSel1,modeSel2, A,B, expUp, expCount}
  localparam logic [36:0] VEC [NVEC] = '{
    {2'b10, 2'b10, 1'b1, 32'd1},   // R1 R5 fine forward
    {2'b10, 2'b11, 1'b1, 32'd2},
    {2'b10, 2'b01, 1'b1, 32'd3},
    {2'b10, 2'b00, 1'b1, 32'd4},
    {2'b10, 2'b01, 1'b0, 32'd3},   // R5 reverse
    {2'b10, 2'b11, 1'b0, 32'd2},
    {2'b01, 2'b10, 1'b0, 32'd2},   // R2 B edge ignored
    {2'b01, 2'b00, 1'b0, 32'd1},
    {2'b01, 2'b10, 1'b1, 32'd2},
    {2'b01, 2'b11, 1'b1, 32'd2},
    {2'b01, 2'b01, 1'b1, 32'd3},
    {2'b01, 2'b00, 1'b1, 32'd3},
    {2'b11, 2'b10, 1'b1, 32'd4},   // R3 coarse
    {2'b11, 2'b11, 1'b1, 32'd4},
    {2'b11, 2'b01, 1'b1, 32'd4},
    {2'b11, 2'b00, 1'b1, 32'd4},
    {2'b11, 2'b10, 1'b1, 32'd5},
    {2'b11, 2'b00, 1'b0, 32'd4},
    {2'b00, 2'b10, 1'b0, 32'd4},   // R4 off code
    {2'b00, 2'b11, 1'b0, 32'd4},
    {2'b10, 2'b00, 1'b0, 32'd4},   // R8 double jump
    {2'b10, 2'b01, 1'b0, 32'd3}
  };

  task automatic check(string tag, logic [CNT_W-1:0] act, logic [CNT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic stepTo(logic a, logic b);
    pulses = 0;
    chanA = a;
    chanB = b;
    settle();
  endtask

  initial begin
    logic [CNT_W-1:0] prevExp;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 count in reset", count, 0);
    check("R11 pulse in reset", {31'd0, countPulse}, 0);
    check("R11 upDn in reset", {31'd0, upDn}, 1);
    rstN = 1'b1;
    settle();

    prevExp = '0;
    for (int i = 0; i < NVEC; i++) begin
      modeSel1 = VEC[i][36];
      modeSel2 = VEC[i][35];
      stepTo(VEC[i][34], VEC[i][33]);
      check($sformatf("R1-table count step %0d", i), count, VEC[i][31:0]);
      check($sformatf("R6 upDn step %0d", i), {31'd0, upDn}, {31'd0, VEC[i][32]});
      check($sformatf("R7 pulses step %0d", i), pulses,
            (VEC[i][31:0] != prevExp) ? 1 : 0);
      prevExp = VEC[i][31:0];
    end

    // R9 glitch of two clocks rejected (fine mode, AB=01, count 3)
    pulses = 0;
    chanA = 1'b1;
    repeat (2) @(negedge clk);
    chanA = 1'b0;
    settle();
    check("R9 short glitch count", count, 3);
    check("R9 short glitch pulses", pulses, 0);
    // R9 three-clock pulse accepted: back then forward
    pulses = 0;
    chanA = 1'b1;
    repeat (3) @(negedge clk);
    chanA = 1'b0;
    settle();
    check("R9 accepted pulses", pulses, 2);
    check("R9 accepted count", count, 3);

    // R11 asynchronous reset while running
    #1 rstN = 1'b0;
    #1;
    check("R11 async clear", count, 0);
    check("R11 async upDn", {31'd0, upDn}, 1);
    chanA = 1'b0;
    chanB = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    settle();
    check("R11 after release", count, 0);

    // R10 wrap both ways
    modeSel1 = 1'b1;
    modeSel2 = 1'b0;
    stepTo(1'b0, 1'b1);
    check("R10 wrap down", count, 32'hFFFF_FFFF);
    check("R10 dir down", {31'd0, upDn}, 0);
    stepTo(1'b0, 1'b0);
    check("R10 wrap up", count, 0);
    check("R10 pulse once", pulses, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule